// File: doc/BRIEF.md
# Parallel Flash Programming Mode Controller

This block is the device-side engine that an external programmer talks to when the chip is placed in its parallel programming mode. Through a handful of level pins, a strobe and an 8-bit data bus, the programmer can read and write bytes of an on-chip code array, wipe the whole array, set two protection bits, and read back fixed identification bytes. There is no address bus. An internal address counter is cleared when the enable pin rises and moves forward by one on each pulse of a separate step pin. The array itself is a simple synchronous byte memory inside the block.

All pins are sampled through two-flop synchronizers. Each sampled pin pattern decodes to one mode. A falling edge on the strobe while in a write, lock or erase mode starts that operation, and `ready` stays low until it finishes. The controller is a four-state machine:
- `ST_IDLE` serves reads and waits for a strobe edge.
- `ST_WR_BUSY` times a byte write or lock write.
- `ST_ER_HOLD` counts how long the strobe is held low for an erase.
- `ST_ER_SWEEP` writes FFH to every address.

The transitions are:
- IDLE→WR_BUSY on a strobe fall in write or lock mode.
- IDLE→ER_HOLD on a strobe fall in erase mode.
- WR_BUSY→IDLE when `WRITE_CYC` cycles have elapsed.
- ER_HOLD→IDLE (abort) if the strobe rises or the mode changes early.
- ER_HOLD→ER_SWEEP after `ERASE_CYC` cycles of hold.
- ER_SWEEP→IDLE after the last address has been written.

Top module: `flash_prog_ctrl`

## Requirements
- R1: The address counter returns to 0 on each rising edge of `prog_en` and increments by one on each rising edge of `step`.
- R2: Stepping from the highest address (2^ADDR_W − 1) wraps the counter to address 0.
- R3: Read mode is `prog_en`=1, `vpp_hi`=0, `prog_n`=1 and `mode_sel`=4'b1100, where `mode_sel` is ordered {line7, line5, line4, line3}. In this mode `dout_oe`=1 and `dout` shows the array byte at the current address.
- R4: Signature mode is `prog_en`=1, `vpp_hi`=0, `prog_n`=1 and `mode_sel`=4'b0000. It returns 1EH at address 0, 41H at address 1, 5AH at address 2 and FFH elsewhere.
- R5: A falling edge of `prog_n` with `prog_en`=1, `vpp_hi`=1 and `mode_sel`=4'b1111 stores (old byte AND `din`) at the current address. After that edge, `ready` is low for `WRITE_CYC` cycles and then returns high.
- R6: A falling edge of `prog_n` with `vpp_hi`=1 and `mode_sel`=4'b0001 starts an erase, provided `prog_n` is then held low for `ERASE_CYC` cycles. The erase sets every byte to FFH and clears both lock bits, and `ready` is low from the strobe edge until the sweep ends.
- R7: If `prog_n` rises before `ERASE_CYC` cycles have passed, the erase is aborted and the array is left unchanged.
- R8: A strobe fall with `vpp_hi`=1 sets lock bit 1 when `mode_sel`=4'b0011 and lock bit 2 when `mode_sel`=4'b0101. While either lock bit is set, read mode returns FFH; signature reads are unaffected.
- R9: Any other pin combination, including `prog_en`=0, is idle. In idle, `dout_oe`=0 and `dout`=0, and a strobe pulse does not change the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | Programming enable (logic-high reset level); rising edge clears the address |
| vpp_hi | input | 1 | High programming voltage present |
| prog_n | input | 1 | Active-low program strobe |
| mode_sel | input | 4 | Mode select lines {line7, line5, line4, line3} |
| step | input | 1 | Address advance pulse |
| din | input | 8 | Data bus in from the programmer |
| dout | output | 8 | Data bus out to the programmer |
| dout_oe | output | 1 | Data bus output enable |
| ready | output | 1 | High when idle, low while a write or erase is running |

## Verification
The assertions assume that the programmer changes the mode lines only while `prog_n` is high. They also assume that every pin holds steady for several clock cycles, so that all synchronizer bits settle to one consistent pattern before a strobe edge. The stimulus changes pins only at falling clock edges, waits at least four cycles between a mode change and a strobe edge, and holds each step pulse high and then low for three cycles. The write-safety check also assumes that the array contents are defined, so the stimulus runs a full erase before any write.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_BUSY,
        ST_ER_HOLD,
        ST_ER_SWEEP
    } fpc_state_e;

    typedef enum logic [2:0] {
        MD_IDLE,
        MD_READ,
        MD_SIG,
        MD_WRITE,
        MD_ERASE,
        MD_LOCK1,
        MD_LOCK2
    } fpc_mode_e;

    // select lines ordered {line7, line5, line4, line3}
    localparam logic [3:0] SEL_READ  = 4'b1100;
    localparam logic [3:0] SEL_SIG   = 4'b0000;
    localparam logic [3:0] SEL_WRITE = 4'b1111;
    localparam logic [3:0] SEL_ERASE = 4'b0001;
    localparam logic [3:0] SEL_LOCK1 = 4'b0011;
    localparam logic [3:0] SEL_LOCK2 = 4'b0101;

    localparam logic [7:0] SIG_B0 = 8'h1E;
    localparam logic [7:0] SIG_B1 = 8'h41;
    localparam logic [7:0] SIG_B2 = 8'h5A;

    function automatic fpc_mode_e decode_mode(input logic en, input logic vpp,
                                              input logic strb_n, input logic [3:0] sel);
        fpc_mode_e m;
        m = MD_IDLE;
        if (en && !vpp && strb_n) begin
            if (sel == SEL_READ)      m = MD_READ;
            else if (sel == SEL_SIG)  m = MD_SIG;
        end else if (en && vpp) begin
            if (sel == SEL_WRITE)      m = MD_WRITE;
            else if (sel == SEL_ERASE) m = MD_ERASE;
            else if (sel == SEL_LOCK1) m = MD_LOCK1;
            else if (sel == SEL_LOCK2) m = MD_LOCK2;
        end
        return m;
    endfunction

endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fpc_addr_ctr.sv
module fpc_addr_ctr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr <= '0;
        else if (clr)    addr <= '0;
        else if (inc)    addr <= addr + 1'b1;
    end

    assert_step_incr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && addr != ADDR_MAX) |=> addr == $past(addr) + 1'b1);

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> addr == '0);

    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && addr == ADDR_MAX) |=> addr == '0);
endmodule

// File: rtl/fpc_mem.sv
module fpc_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
        rdata <= cells[addr];
    end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WRITE_CYC = 64,
    parameter int ERASE_CYC = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_en,
    input  logic       vpp_hi,
    input  logic       prog_n,
    input  logic [3:0] mode_sel,
    input  logic       step,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       dout_oe,
    output logic       ready
);
    localparam int CNT_MAX = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0]  WR_LAST = CNT_W'(WRITE_CYC - 1);
    localparam logic [CNT_W-1:0]  ER_LAST = CNT_W'(ERASE_CYC - 1);
    localparam logic [ADDR_W-1:0] A_LAST  = '1;

    // pin synchronizers
    logic [7:0] pins_s;
    logic       en_s, vpp_s, strn_s, step_s;
    logic [3:0] sel_s;

    fpc_sync #(.WIDTH(8), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({prog_en, vpp_hi, prog_n, step, mode_sel}),
        .q(pins_s)
    );
    assign {en_s, vpp_s, strn_s, step_s, sel_s} = pins_s;

    logic en_d, strn_d, step_d;
    logic en_rise, str_fall, step_rise;
    assign en_rise   = en_s & ~en_d;
    assign str_fall  = strn_d & ~strn_s;
    assign step_rise = step_s & ~step_d;

    fpc_mode_e mode;
    assign mode = decode_mode(en_s, vpp_s, strn_s, sel_s);

    logic [ADDR_W-1:0] addr;
    fpc_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(en_rise), .inc(step_rise), .addr(addr)
    );

    fpc_state_e        state, state_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] sweep;
    logic [1:0]        lock;
    logic [7:0]        wdata_q;
    logic              op_wr;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_q;

    fpc_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
        .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_q)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (str_fall) begin
                    if (mode == MD_WRITE || mode == MD_LOCK1 || mode == MD_LOCK2)
                        state_nxt = ST_WR_BUSY;
                    else if (mode == MD_ERASE)
                        state_nxt = ST_ER_HOLD;
                end
            end
            ST_WR_BUSY:  if (cnt == WR_LAST) state_nxt = ST_IDLE;
            ST_ER_HOLD: begin
                if (strn_s || mode != MD_ERASE) state_nxt = ST_IDLE;
                else if (cnt == ER_LAST)        state_nxt = ST_ER_SWEEP;
            end
            ST_ER_SWEEP: if (sweep == A_LAST) state_nxt = ST_IDLE;
            default:     state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sweep   <= '0;
            lock    <= '0;
            wdata_q <= '0;
            op_wr   <= 1'b0;
            en_d    <= 1'b0;
            strn_d  <= 1'b0;
            step_d  <= 1'b0;
        end else begin
            en_d   <= en_s;
            strn_d <= strn_s;
            step_d <= step_s;
            state  <= state_nxt;
            cnt    <= (state_nxt != state) ? '0 : cnt + 1'b1;
            sweep  <= (state == ST_ER_SWEEP) ? sweep + 1'b1 : '0;
            if (state == ST_IDLE && str_fall) begin
                op_wr   <= (mode == MD_WRITE);
                wdata_q <= din;
                if (mode == MD_LOCK1) lock[0] <= 1'b1;
                if (mode == MD_LOCK2) lock[1] <= 1'b1;
            end
            if (state == ST_ER_SWEEP && state_nxt == ST_IDLE) lock <= '0;
        end
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = addr;
        mem_wdata = mem_q & wdata_q;
        ready     = 1'b0;
        dout_oe   = 1'b0;
        dout      = 8'h00;
        unique case (state)
            ST_IDLE: begin
                ready = 1'b1;
                if (mode == MD_READ) begin
                    dout_oe = 1'b1;
                    dout    = (lock != 2'b00) ? 8'hFF : mem_q;
                end else if (mode == MD_SIG) begin
                    dout_oe = 1'b1;
                    if (addr == ADDR_W'(0))      dout = SIG_B0;
                    else if (addr == ADDR_W'(1)) dout = SIG_B1;
                    else if (addr == ADDR_W'(2)) dout = SIG_B2;
                    else                         dout = 8'hFF;
                end
            end
            ST_WR_BUSY:  mem_we = op_wr && (cnt == '0);
            ST_ER_HOLD:  mem_we = 1'b0;
            ST_ER_SWEEP: begin
                mem_we    = 1'b1;
                mem_addr  = sweep;
                mem_wdata = 8'hFF;
            end
            default: ;
        endcase
    end

    assert_busy_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && str_fall && mode == MD_WRITE) |=> !ready);

    assert_write_clears_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state == ST_WR_BUSY) |-> ((mem_wdata & ~mem_q) == 8'h00));

    assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ER_HOLD) |-> !mem_we);

    assert_erase_clears_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ER_SWEEP && state_nxt == ST_IDLE) |=> (lock == 2'b00));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_IDLE) |-> (!dout_oe && dout == 8'h00));

    assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mem_we);
endmodule

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;
    localparam int ADDR_W    = 8;
    localparam int WRITE_CYC = 20;
    localparam int ERASE_CYC = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_en = 1'b0, vpp_hi = 1'b0, prog_n = 1'b1, step = 1'b0;
    logic [3:0] mode_sel = 4'b1010;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe, ready;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    flash_prog_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .vpp_hi(vpp_hi), .prog_n(prog_n),
        .mode_sel(mode_sel), .step(step), .din(din), .dout(dout), .dout_oe(dout_oe),
        .ready(ready)
    );

    // {address, write data, expected byte after write}
    localparam logic [23:0] VEC [6] = '{
        {8'h00, 8'hA5, 8'hA5},
        {8'h01, 8'h3C, 8'h3C},
        {8'h10, 8'h00, 8'h00},
        {8'hFF, 8'h7E, 8'h7E},
        {8'h00, 8'h5A, 8'h00},
        {8'h01, 8'hF0, 8'h30}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic park();
        vpp_hi = 1'b0; prog_n = 1'b1; mode_sel = 4'b1010;
        tick(4);
    endtask

    task automatic goto_addr(input int a);
        park();
        prog_en = 1'b0; tick(4);
        prog_en = 1'b1; tick(4);
        for (int i = 0; i < a; i++) begin
            step = 1'b1; tick(3);
            step = 1'b0; tick(3);
        end
    endtask

    task automatic read_at(input int a, input logic [3:0] sel, output logic [7:0] d);
        goto_addr(a);
        mode_sel = sel; tick(8);
        d = dout;
        park();
    endtask

    task automatic strobe_op(input logic [3:0] sel, input logic [7:0] dat);
        vpp_hi = 1'b1; mode_sel = sel; din = dat; tick(4);
        prog_n = 1'b0; tick(4);
        prog_n = 1'b1; tick(WRITE_CYC + 10);
        park();
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 2000 && !ready; i++) tick(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        tick(3);
        rst_n = 1'b1;
        tick(6);
        // reset state: idle pins
        check("R9 reset ready", {7'd0, ready}, 8'h01);
        check("R9 reset oe", {7'd0, dout_oe}, 8'h00);
        check("R9 reset dout", dout, 8'h00);

        // full erase to define contents; R6 busy during hold
        goto_addr(0);
        vpp_hi = 1'b1; mode_sel = 4'b0001; tick(4);
        prog_n = 1'b0; tick(ERASE_CYC / 2);
        check("R6 busy in hold", {7'd0, ready}, 8'h00);
        tick(ERASE_CYC / 2 + 20);
        prog_n = 1'b1;
        wait_ready();
        park();
        read_at(7, 4'b1100, rd);
        check("R6 erased byte", rd, 8'hFF);

        // vector table: write then read back (R1 R3 R5)
        for (int v = 0; v < 6; v++) begin
            goto_addr(int'(VEC[v][23:16]));
            strobe_op(4'b1111, VEC[v][15:8]);
            read_at(int'(VEC[v][23:16]), 4'b1100, rd);
            check("R1 R3 R5 table read", rd, VEC[v][7:0]);
        end

        // R5 busy timing
        goto_addr(32);
        vpp_hi = 1'b1; mode_sel = 4'b1111; din = 8'h81; tick(4);
        prog_n = 1'b0; tick(4);
        check("R5 busy during write", {7'd0, ready}, 8'h00);
        prog_n = 1'b1; tick(WRITE_CYC + 10);
        check("R5 ready after write", {7'd0, ready}, 8'h01);
        park();
        read_at(32, 4'b1100, rd);
        check("R5 written byte", rd, 8'h81);

        // R4 signature bytes
        read_at(0, 4'b0000, rd); check("R4 sig addr0", rd, 8'h1E);
        read_at(1, 4'b0000, rd); check("R4 sig addr1", rd, 8'h41);
        read_at(2, 4'b0000, rd); check("R4 sig addr2", rd, 8'h5A);
        read_at(3, 4'b0000, rd); check("R4 sig addr3", rd, 8'hFF);

        // R2 wrap: 257 steps lands on address 1
        read_at(257, 4'b1100, rd);
        check("R2 wrap to addr1", rd, 8'h30);

        // R9 undefined combo: no drive, no change
        goto_addr(1);
        vpp_hi = 1'b1; mode_sel = 4'b1010; din = 8'h00; tick(6);
        check("R9 undefined oe", {7'd0, dout_oe}, 8'h00);
        check("R9 undefined dout", dout, 8'h00);
        prog_n = 1'b0; tick(ERASE_CYC + 20); prog_n = 1'b1; tick(10);
        park();
        read_at(1, 4'b1100, rd);
        check("R9 array unchanged", rd, 8'h30);

        // R7 aborted erase
        goto_addr(0);
        vpp_hi = 1'b1; mode_sel = 4'b0001; tick(4);
        prog_n = 1'b0; tick(ERASE_CYC / 2);
        check("R7 busy in short hold", {7'd0, ready}, 8'h00);
        prog_n = 1'b1; tick(10);
        check("R7 ready after abort", {7'd0, ready}, 8'h01);
        park();
        read_at(1, 4'b1100, rd);   check("R7 addr1 kept", rd, 8'h30);
        read_at(255, 4'b1100, rd); check("R7 addrFF kept", rd, 8'h7E);

        // R8 lock bit 1
        goto_addr(0);
        strobe_op(4'b0011, 8'h00);
        read_at(1, 4'b1100, rd); check("R8 lock1 read masked", rd, 8'hFF);
        read_at(1, 4'b0000, rd); check("R8 lock1 sig ok", rd, 8'h41);

        // R6 full erase clears array and locks
        goto_addr(0);
        vpp_hi = 1'b1; mode_sel = 4'b0001; tick(4);
        prog_n = 1'b0; tick(ERASE_CYC + 20);
        prog_n = 1'b1;
        wait_ready();
        park();
        goto_addr(16);
        strobe_op(4'b1111, 8'h12);
        read_at(16, 4'b1100, rd);  check("R6 lock cleared", rd, 8'h12);
        read_at(255, 4'b1100, rd); check("R6 addrFF erased", rd, 8'hFF);

        // R8 lock bit 2
        goto_addr(0);
        strobe_op(4'b0101, 8'h00);
        read_at(16, 4'b1100, rd); check("R8 lock2 read masked", rd, 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule